// File: doc/BRIEF.md
# Upper Memory Chip Select Decoder

This block decodes the 20-bit address of each bus cycle. When the cycle targets a programmable window at the top of the address space, it drives an active-low chip select. The window always ends at the last byte of the address space, so choosing its size also sets its base. The size comes from a small configuration register, and after reset the window spans the topmost 64 KB so that the boot vector can be fetched. Once software has copied its code out and turns on the DRAM bank, the select is shut off for good. Only a reset brings it back.

The select and a zero-page indicator are captured when a bus cycle begins. They hold steady until the cycle-end strobe, even if the address lines move during the cycle. The zero-page indicator flags any cycle whose four upper address bits are all zero, which covers the interrupt vector region. While another master holds the bus, the select output's enable is dropped so that the pin can float.

Top module: `ucs_decoder`

## Requirements
- R1: After reset the size code is 0, the window is F0000h..FFFFFh, and ucs_n is 1, uzi is 0.
- R2: Size code k (0 to 3, written with size_wr) selects a window of 64 KB << k ending at FFFFFh, with lower bounds F0000h, E0000h, C0000h and 80000h.
- R3: A size_wr carrying a code of 4 to 7 is ignored, and the previously programmed window stays in force.
- R4: When cyc_start is sampled with an address inside the window, ucs_n is low from the next cycle and stays low, whatever the address does, until the edge that samples cyc_end. At that edge it returns high, and uzi drops to 0.
- R5: A cycle started with an address below the window leaves ucs_n high.
- R6: The edge that samples dram_bank_on high forces ucs_n high, including a select that is already active. Every later cycle then leaves ucs_n high, until reset.
- R7: ucs_oe is the inverse of hold_gnt in every cycle. The chip-select value underneath keeps following the decode.
- R8: uzi is 1 from the cycle after cyc_start when address bits 19..16 were all zero, and 0 otherwise. It holds until the cycle ends, regardless of address changes.
- R9: When cyc_start and cyc_end are sampled in the same cycle, the new cycle's decode is captured. The end strobe does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Bus address |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_end | input | 1 | Bus cycle end strobe |
| hold_gnt | input | 1 | Bus hold granted to another master |
| size_wr | input | 1 | Write strobe for the size code |
| size_code | input | 3 | Window size code |
| dram_bank_on | input | 1 | DRAM bank activation |
| ucs_n | output | 1 | Upper chip select, active low |
| ucs_oe | output | 1 | Output enable of ucs_n |
| uzi | output | 1 | Zero-page indicator |

## Verification
The bench probes each window at its exact lower bound and one byte below it. An off-by-one in the bound comparison would show up there, either as a select on the byte below or as no select on the bound itself. After every start strobe it scrambles the address, so a decoder that tracks the live address instead of the captured one would change ucs_n or uzi in the middle of a cycle. It also covers several other cases:
- Invalid size codes are written, and the bench checks that they do not shrink or widen the window.
- The DRAM lock is raised while a select is active, to catch a design that waits for the cycle to end.
- A reset is applied after the lock, to confirm that the lock and the size register both come back to their defaults.
- A start and an end strobe are sampled together, which exposes a design that lets the end strobe win.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
    localparam int UCS_ADDR_W = 20;
    localparam int UCS_PAGE_W = 4;   // address bits above one 64 KB page
    localparam int UCS_CODE_W = 3;

    typedef struct packed {
        logic sel;
        logic zero;
    } ucs_cyc_t;
endpackage

// File: rtl/ucs_size_reg.sv
module ucs_size_reg #(
    parameter int CODE_W    = 3,
    parameter int NUM_CODES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    output logic [CODE_W-1:0] code_q
);
    localparam logic [CODE_W-1:0] CODE_LIMIT = CODE_W'(NUM_CODES);

    logic [CODE_W-1:0] code_d;

    // Only codes that name a supported block size are accepted.
    always_comb begin
        code_d = code_q;
        if (wr_en && (wr_code < CODE_LIMIT)) begin
            code_d = wr_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end
endmodule

// File: rtl/ucs_window_match.sv
module ucs_window_match #(
    parameter int PAGE_W    = 4,
    parameter int CODE_W    = 3,
    parameter int NUM_CODES = 4
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [CODE_W-1:0] code,
    output logic              hit,
    output logic              zero
);
    localparam int NUM_PAGES = 1 << PAGE_W;

    logic [NUM_CODES-1:0] hit_vec;

    // One comparator per size code: the window starts 2^g pages below the top.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_size
        localparam logic [PAGE_W:0] LOW_PAGE = (PAGE_W+1)'(NUM_PAGES - (1 << g));
        assign hit_vec[g] = ({1'b0, page} >= LOW_PAGE);
    end

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_CODES; i++) begin
            if (code == CODE_W'(i)) begin
                hit = hit_vec[i];
            end
        end
    end

    assign zero = (page == '0);
endmodule

// File: rtl/ucs_dram_lock.sv
module ucs_dram_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic locked_q
);
    logic locked_d;

    // Sticky: once set, only reset clears it.
    always_comb begin
        locked_d = locked_q | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else begin
            locked_q <= locked_d;
        end
    end
endmodule

// File: rtl/ucs_decoder.sv
module ucs_decoder
    import ucs_pkg::*;
#(
    parameter int ADDR_W = UCS_ADDR_W,
    parameter int PAGE_W = UCS_PAGE_W,
    parameter int CODE_W = UCS_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cyc_start,
    input  logic              cyc_end,
    input  logic              hold_gnt,
    input  logic              size_wr,
    input  logic [CODE_W-1:0] size_code,
    input  logic              dram_bank_on,
    output logic              ucs_n,
    output logic              ucs_oe,
    output logic              uzi
);
    // Largest block is half the address space, so one code per page bit.
    localparam int NUM_CODES = PAGE_W;
    localparam int LOW_W     = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] page;
    logic [CODE_W-1:0] code_q;
    logic              hit;
    logic              zero;
    logic              locked_q;
    logic              unused_low;
    ucs_cyc_t          cyc_d;
    ucs_cyc_t          cyc_q;

    assign page       = addr[ADDR_W-1 -: PAGE_W];
    assign unused_low = ^addr[LOW_W-1:0];

    ucs_size_reg #(
        .CODE_W    (CODE_W),
        .NUM_CODES (NUM_CODES)
    ) u_size (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (size_wr),
        .wr_code (size_code),
        .code_q  (code_q)
    );

    ucs_window_match #(
        .PAGE_W    (PAGE_W),
        .CODE_W    (CODE_W),
        .NUM_CODES (NUM_CODES)
    ) u_match (
        .page (page),
        .code (code_q),
        .hit  (hit),
        .zero (zero)
    );

    ucs_dram_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (dram_bank_on),
        .locked_q (locked_q)
    );

    // Cycle state: captured on start, cleared on end; start has priority.
    always_comb begin
        cyc_d = cyc_q;
        if (cyc_start) begin
            cyc_d.sel  = hit & ~locked_q;
            cyc_d.zero = zero;
        end else if (cyc_end) begin
            cyc_d = '0;
        end
        if (dram_bank_on) begin
            cyc_d.sel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_d;
        end
    end

    assign ucs_n  = ~cyc_q.sel;
    assign uzi    = cyc_q.zero;
    assign ucs_oe = ~hold_gnt;
endmodule

// File: rtl/ucs_decoder_chk.sv
module ucs_decoder_chk #(
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PAGE_W-1:0] page,
    input logic              cyc_start,
    input logic              cyc_end,
    input logic              hold_gnt,
    input logic              dram_bank_on,
    input logic              ucs_n,
    input logic              ucs_oe,
    input logic              uzi
);
    logic lock_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_seen_q <= 1'b0;
        end else if (dram_bank_on) begin
            lock_seen_q <= 1'b1;
        end
    end

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ucs_n && !cyc_start && !cyc_end && !dram_bank_on) |=> $stable(ucs_n)); // R4
    AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && !cyc_start) |=> (ucs_n && !uzi)); // R4
    AST_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !page[PAGE_W-1]) |=> ucs_n); // R5
    AST_LOCK_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        dram_bank_on |=> ucs_n); // R6
    AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_seen_q |-> ucs_n); // R6
    AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        hold_gnt |-> !ucs_oe); // R7
    AST_ZERO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && (page != '0)) |=> !uzi); // R8
    AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && cyc_end && (page == '0)) |=> uzi); // R9
endmodule

bind ucs_decoder ucs_decoder_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .page         (addr[ADDR_W-1 -: PAGE_W]),
    .cyc_start    (cyc_start),
    .cyc_end      (cyc_end),
    .hold_gnt     (hold_gnt),
    .dram_bank_on (dram_bank_on),
    .ucs_n        (ucs_n),
    .ucs_oe       (ucs_oe),
    .uzi          (uzi)
);

// File: tb/ucs_decoder_bench.sv
module ucs_decoder_bench;
    typedef struct {
        logic  ucs_n;
        logic  uzi;
        logic  oe;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        cyc_start = 1'b0;
    logic        cyc_end = 1'b0;
    logic        hold_gnt = 1'b0;
    logic        size_wr = 1'b0;
    logic [2:0]  size_code = '0;
    logic        dram_bank_on = 1'b0;
    logic        ucs_n;
    logic        ucs_oe;
    logic        uzi;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    ucs_decoder u_ucs_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cyc_start(cyc_start),
        .cyc_end(cyc_end), .hold_gnt(hold_gnt), .size_wr(size_wr),
        .size_code(size_code), .dram_bank_on(dram_bank_on),
        .ucs_n(ucs_n), .ucs_oe(ucs_oe), .uzi(uzi)
    );

    // Monitor: compares queued expectations at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (ucs_n !== e.ucs_n || uzi !== e.uzi || ucs_oe !== e.oe) begin
                    n_fail++;
                    $display("FAIL %s: ucs_n/uzi/oe = %b%b%b expected %b%b%b",
                             e.tag, ucs_n, uzi, ucs_oe, e.ucs_n, e.uzi, e.oe);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_now(input logic n, input logic z, input string tag);
        exp_t e;
        e.ucs_n = n; e.uzi = z; e.oe = ~hold_gnt; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic write_size(input logic [2:0] code);
        size_code = code; size_wr = 1'b1;
        step();
        size_wr = 1'b0;
    endtask

    // One full bus cycle; address is scrambled after the start strobe.
    task automatic bus_cycle(input logic [19:0] a, input logic sel,
                             input logic z, input string tag);
        addr = a; cyc_start = 1'b1;
        step();
        cyc_start = 1'b0; addr = ~a;
        expect_now(~sel, z, tag);
        step();
        expect_now(~sel, z, {tag, " held"});
        cyc_end = 1'b1;
        step();
        cyc_end = 1'b0;
        expect_now(1'b1, 1'b0, "R4 end of cycle");
        step();
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        expect_now(1'b1, 1'b0, "R1 reset state");
        step();
        // R1 default window
        bus_cycle(20'hFFFF0, 1'b1, 1'b0, "R1 boot vector");
        bus_cycle(20'hF0000, 1'b1, 1'b0, "R1 window low bound");
        bus_cycle(20'hEFFFF, 1'b0, 1'b0, "R5 below default window");
        // R8 zero page
        bus_cycle(20'h00010, 1'b0, 1'b1, "R8 zero page");
        bus_cycle(20'h10000, 1'b0, 1'b0, "R8 page one");
        // R2 sizes
        write_size(3'd1);
        bus_cycle(20'hE0000, 1'b1, 1'b0, "R2 128K bound");
        bus_cycle(20'hDFFFF, 1'b0, 1'b0, "R2 128K below");
        write_size(3'd3);
        bus_cycle(20'h80000, 1'b1, 1'b0, "R2 512K bound");
        bus_cycle(20'h7FFFF, 1'b0, 1'b0, "R2 512K below");
        write_size(3'd2);
        bus_cycle(20'hC0000, 1'b1, 1'b0, "R2 256K bound");
        bus_cycle(20'hBFFFF, 1'b0, 1'b0, "R2 256K below");
        // R3 invalid codes ignored
        write_size(3'd5);
        bus_cycle(20'hBFFFF, 1'b0, 1'b0, "R3 code 5 ignored below");
        bus_cycle(20'hC0000, 1'b1, 1'b0, "R3 code 5 ignored bound");
        write_size(3'd7);
        bus_cycle(20'hC0000, 1'b1, 1'b0, "R3 code 7 ignored");
        write_size(3'd4);
        bus_cycle(20'hBFFFF, 1'b0, 1'b0, "R3 code 4 ignored");
        // R7 hold
        hold_gnt = 1'b1;
        bus_cycle(20'hFFFF0, 1'b1, 1'b0, "R7 hold floats select");
        hold_gnt = 1'b0;
        expect_now(1'b1, 1'b0, "R7 hold released");
        step();
        // R9 start and end together
        write_size(3'd0);
        addr = 20'hFFFF0; cyc_start = 1'b1;
        step();
        expect_now(1'b0, 1'b0, "R9 first cycle");
        addr = 20'h00000; cyc_end = 1'b1;
        step();
        cyc_start = 1'b0; cyc_end = 1'b0;
        expect_now(1'b1, 1'b1, "R9 start wins over end");
        cyc_end = 1'b1;
        step();
        cyc_end = 1'b0;
        expect_now(1'b1, 1'b0, "R9 closed");
        step();
        // R6 DRAM lock during an active select
        addr = 20'hFFFF0; cyc_start = 1'b1;
        step();
        cyc_start = 1'b0;
        expect_now(1'b0, 1'b0, "R6 select before lock");
        dram_bank_on = 1'b1;
        step();
        dram_bank_on = 1'b0;
        expect_now(1'b1, 1'b0, "R6 lock kills active select");
        cyc_end = 1'b1;
        step();
        cyc_end = 1'b0;
        step();
        bus_cycle(20'hFFFF0, 1'b0, 1'b0, "R6 locked boot vector");
        bus_cycle(20'hF8000, 1'b0, 1'b0, "R6 locked window");
        // Reset clears lock and size
        write_size(3'd3);
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        expect_now(1'b1, 1'b0, "R1 reset state again");
        step();
        bus_cycle(20'hFFFF0, 1'b1, 1'b0, "R6 reset clears lock");
        bus_cycle(20'hE0000, 1'b0, 1'b0, "R1 reset restores 64K");
        step(); step();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule